// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block derives the serial clock timing of an I2C master from the module clock. It uses two division stages. The first is a prescaler that divides the module clock by 1 to 4 and produces a one-cycle enable, the internal I2C tick. The second counts those ticks to form the SCL waveform. One SCL period lasts SCGD*8 + 20 internal ticks, where SCGD is a 6-bit divider field. Firmware chooses both fields so that the internal tick rate stays below 20 MHz and the SCL rate lands near its target. It then writes them together as one 8-bit control word.

The generator stays released, with SCL high and no ticks, from reset until the first control write. Each write restarts the waveform at the start of a low phase. From then on SCL toggles freely with equal high and low halves. A single-cycle phase tick marks the last module-clock cycle of every half, so the byte engine can step its shift logic in lockstep. The byte engine can stretch the clock with the hold input, which freezes the low half for as long as it is asserted.

Top module: `i2c_rate_div`

## Requirements
- R1: After a synchronous active-high reset, `scl_out` is 1, and `ick_en` and `phase_tick` are 0. They stay at these values until the first control write.
- R2: A control write (`cfg_wr` high at a clock edge) takes the prescale field CDF from `cfg_word[1:0]` and the divider field SCGD from `cfg_word[7:2]`.
- R3: Once configured, `ick_en` is high for one clock in every CDF+1 clocks. The first pulse comes CDF+1 clocks after the write.
- R4: Each SCL low half and each high half lasts (SCGD*4 + 10)*(CDF+1) module clocks, so one period is SCGD*8 + 20 internal ticks.
- R5: A written SCGD of 63 is out of range and is handled exactly as SCGD = 62.
- R6: `phase_tick` is high in exactly one clock per half: the last clock before `scl_out` changes. `scl_out` changes only after a `phase_tick` or a control write.
- R7: While `hold` is high during a low half, the low half is frozen. With CDF = 0 it lengthens by exactly the number of held clocks. `hold` has no effect during a high half.
- R8: In the clock after a control write, `scl_out` is 0 and a fresh, full-length low half begins. This holds even when the write lands mid-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_word | input | 8 | Control word: CDF in [1:0], SCGD in [7:2] |
| hold | input | 1 | Clock-stretch request; freezes the SCL low half |
| ick_en | output | 1 | Prescaled internal I2C tick enable |
| phase_tick | output | 1 | Last clock of the current SCL half |
| scl_out | output | 1 | Free-running SCL level (1 = released) |

## Verification
Periods are measured for CDF 0 and 3 with a small SCGD and with the largest usable SCGD. This separates an error in the prescaler from an error in the fixed offset or in the scaling of the divider field. Writing SCGD = 63 tells a clamp apart from a raw or wrapped value. Holding for a known count in the low half and then in the high half shows that stretching lengthens only the low half. A rewrite in the middle of a high half confirms that the new timing starts from a clean low half.

// File: rtl/i2c_rate_div.sv
module i2c_rate_div #(
  parameter int PRE_W   = 2,
  parameter int DIV_W   = 6,
  parameter int DIV_MAX = 62,
  parameter int OFFSET  = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [PRE_W+DIV_W-1:0] cfg_word,
  input  logic                   hold,
  output logic                   ick_en,
  output logic                   phase_tick,
  output logic                   scl_out
);
  localparam int HALF_MAX = DIV_MAX * 4 + OFFSET / 2;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);

  logic [PRE_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_q;
  logic              run_q;
  logic [PRE_W-1:0]  pcnt;
  logic [HALF_W-1:0] scnt;
  logic              scl_q;

  logic [DIV_W-1:0]  wr_div;
  logic [DIV_W-1:0]  wr_div_lim;
  logic [HALF_W-1:0] half_len;
  logic              stall;

  assign wr_div     = cfg_word[PRE_W+DIV_W-1:PRE_W];
  assign wr_div_lim = (wr_div > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : wr_div;
  assign half_len   = (HALF_W'(div_q) << 2) + HALF_W'(OFFSET / 2);

  assign ick_en     = run_q && (pcnt == pre_q);
  assign stall      = hold && !scl_q;
  assign phase_tick = ick_en && !stall && (scnt == half_len - HALF_W'(1));
  assign scl_out    = scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      div_q <= '0;
      run_q <= 1'b0;
      pcnt  <= '0;
      scnt  <= '0;
      scl_q <= 1'b1;
    end else if (cfg_wr) begin
      pre_q <= cfg_word[PRE_W-1:0];
      div_q <= wr_div_lim;
      run_q <= 1'b1;
      pcnt  <= '0;
      scnt  <= '0;
      scl_q <= 1'b0;
    end else if (run_q) begin
      pcnt <= ick_en ? '0 : pcnt + PRE_W'(1);
      if (ick_en && !stall) begin
        if (phase_tick) begin
          scnt  <= '0;
          scl_q <= !scl_q;
        end else begin
          scnt <= scnt + HALF_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_rate_div_chk.sv
module i2c_rate_div_chk (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic hold,
  input logic ick_en,
  input logic phase_tick,
  input logic scl_out
);
  logic seen_wr;
  always_ff @(posedge clk) begin
    if (rst) seen_wr <= 1'b0;
    else if (cfg_wr) seen_wr <= 1'b1;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !seen_wr |-> (scl_out && !ick_en && !phase_tick)); // R1
  AST_TICK_HAS_ICK: assert property (@(posedge clk) disable iff (rst)
    phase_tick |-> ick_en); // R3
  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (phase_tick && !cfg_wr) |=> (scl_out != $past(scl_out))); // R6
  AST_NO_STRAY_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!phase_tick && !cfg_wr) |=> $stable(scl_out)); // R6
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (hold && !scl_out && !cfg_wr) |=> !scl_out); // R7
  AST_WRITE_LOW: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !scl_out); // R8
endmodule

bind i2c_rate_div i2c_rate_div_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .hold(hold),
  .ick_en(ick_en), .phase_tick(phase_tick), .scl_out(scl_out)
);

// File: tb/sim_i2c_rate_div.sv
module sim_i2c_rate_div;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_word = '0;
  logic hold = 1'b0;
  logic ick_en, phase_tick, scl_out;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  i2c_rate_div u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .hold(hold), .ick_en(ick_en), .phase_tick(phase_tick), .scl_out(scl_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int pre, int dv);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_word = 8'((dv << 2) | pre);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R8 scl low after write", int'(scl_out), 0);
  endtask

  task automatic measure(int hlo, int hhi, output int lo, output int hi,
                         output int tk, output int ik);
    lo = 0; hi = 0; tk = 0; ik = 0;
    while (scl_out == 1'b0) begin
      lo++; tk += int'(phase_tick); ik += int'(ick_en);
      hold = (lo <= hlo);
      @(negedge clk);
    end
    hold = 1'b0;
    while (scl_out == 1'b1) begin
      hi++; tk += int'(phase_tick);
      hold = (hi <= hhi);
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic t_reset;
    int bad = 0;
    repeat (3) @(negedge clk);
    chk("R1 scl high in reset", int'(scl_out), 1);
    rst = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (!scl_out || ick_en || phase_tick) bad++;
    end
    chk("R1 released until write", bad, 0);
  endtask

  task automatic t_period(int pre, int dv, int dv_eff, string tag);
    int lo, hi, tk, ik, exp;
    wr(pre, dv);
    measure(0, 0, lo, hi, tk, ik);
    exp = (dv_eff * 4 + 10) * (pre + 1);
    chk({tag, " low half"}, lo, exp);
    chk({tag, " high half"}, hi, exp);
    chk("R6 ticks per period", tk, 2);
    chk("R3 ick pulses in low half", ik, dv_eff * 4 + 10);
  endtask

  task automatic t_hold;
    int lo, hi, tk, ik;
    wr(0, 2);
    measure(7, 0, lo, hi, tk, ik);
    chk("R7 held low stretched", lo, 18 + 7);
    chk("R7 high unaffected", hi, 18);
    wr(0, 2);
    measure(0, 9, lo, hi, tk, ik);
    chk("R7 hold in high ignored", hi, 18);
    chk("R7 low after high hold", lo, 18);
  endtask

  task automatic t_rewrite;
    int lo, hi, tk, ik;
    wr(1, 5);
    while (scl_out == 1'b0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R8 in high before rewrite", int'(scl_out), 1);
    wr(0, 1);
    measure(0, 0, lo, hi, tk, ik);
    chk("R8 fresh low after rewrite", lo, 14);
    chk("R2 new divider in high", hi, 14);
  endtask

  initial begin
    t_reset();
    t_period(0, 0, 0, "R4 cdf0 scgd0");
    t_period(3, 1, 1, "R4 cdf3 scgd1");
    t_period(2, 3, 3, "R2 cdf2 scgd3");
    t_period(1, 62, 62, "R4 cdf1 scgd62");
    t_period(0, 63, 62, "R5 scgd63 clamped");
    t_hold();
    t_rewrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule